// File: doc/BRIEF.md
# Cartridge Bank and Source Decoder

This block turns a cartridge control setting into the three facts each CPU access needs: which bank it hits, which store returns the data, and the physical address to send to that store. The setting is held in a small control register. It has a 3-bit mode field and a bank field, and a single load strobe writes both fields at once.

For each access the CPU side supplies three things. The first is a block index naming the 8 KiB CPU window being touched. The second is a select line that splits the window into two sub-areas. The third is the 13-bit offset inside the window. The decoder answers in the same cycle through combinational logic.

One mode is a boot mode. It exposes flash through a single block, the boot block. All other blocks then float the last value seen on the CPU bus. Other modes pick flash, RAM, or a split between the two that depends on the select line. The bank in these modes either comes from the register or is fixed by the mode.

Top module: `bank_src_decoder`

## Requirements
- R1: After reset the register holds the boot mode (code 0) with bank field 0. An access to a block other than the boot block (index 5) then reports source LAST (code 0) and bank 0.
- R2: When `cfg_load` is high at a rising clock edge, both fields are captured and take effect from that edge on. While `cfg_load` is low, changes on `cfg_mode` and `cfg_bank` have no effect on the outputs.
- R3: In flash mode (1), super-ROM mode (2) and super-RAM mode (3), the bank output equals the register's bank field.
- R4: In ROM/RAM mode (4) and RAM1 mode (5), the bank output is 1 whatever the bank field holds.
- R5: In RAM2 mode (6), the bank output is 2 when `acc_sel` is high and 1 when it is low.
- R6: In boot mode (0) and in the unassigned code 7, the bank output is 0.
- R7: In boot mode, an access to block 5 reports source FLASH (code 1). An access to any other block reports LAST (code 0).
- R8: Flash and super-ROM modes report FLASH. RAM1, RAM2 and super-RAM modes report RAM (code 2).
- R9: In ROM/RAM mode, the source is FLASH when `acc_sel` is high and RAM when it is low.
- R10: Mode code 7 reports source LAST.
- R11: `phys_addr` is the bank output placed above the 13-bit `acc_ofs`, that is `{bank_num, acc_ofs}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for the control register |
| cfg_mode | input | 3 | Mode value to load |
| cfg_bank | input | BANK_W (6) | Bank field value to load |
| acc_blk | input | 3 | CPU block index of the access |
| acc_sel | input | 1 | Sub-area select of the access |
| acc_ofs | input | 13 | Offset inside the block |
| bank_num | output | BANK_W (6) | Decoded bank number |
| data_src | output | 2 | 0 LAST, 1 FLASH, 2 RAM |
| phys_addr | output | BANK_W+13 (19) | Bank above offset |

## Verification
Bank, source and address results are due in the same cycle as the access inputs, because they are combinational from the register and the access lines. The bench therefore drives the access inputs on a falling edge and samples 1 ns later, with no clock edge in between.

A configuration load is due one rising edge after the strobe. The bench raises `cfg_load` on a falling edge, lowers it on the next falling edge, and only then checks the outputs. To show that a change without a load has no effect, the bench alters the config inputs with the strobe low, lets a rising edge pass, and checks that the outputs are unchanged.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
    typedef enum logic [2:0] {
        MD_BOOT     = 3'd0,
        MD_FLASH    = 3'd1,
        MD_SROM     = 3'd2,
        MD_SRAM     = 3'd3,
        MD_ROMRAM   = 3'd4,
        MD_RAM1     = 3'd5,
        MD_RAM2     = 3'd6,
        MD_SPARE    = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SRC_LAST  = 2'd0,
        SRC_FLASH = 2'd1,
        SRC_RAM   = 2'd2
    } src_e;

    localparam int OFS_W = 13;
    localparam int BLK_W = 3;
endpackage

// File: rtl/cfg_reg.sv
module cfg_reg
    import bank_dec_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2:0]        mode_in,
    input  logic [BANK_W-1:0] bank_in,
    output mode_e             mode_q_o,
    output logic [BANK_W-1:0] bank_q_o
);
    typedef struct packed {
        mode_e             mode;
        logic [BANK_W-1:0] bank;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.mode = mode_e'(mode_in);
            cfg_d.bank = bank_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mode <= MD_BOOT;
            cfg_q.bank <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_q_o = cfg_q.mode;
    assign bank_q_o = cfg_q.bank;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mode_q_o == $past(mode_in)) && (bank_q_o == $past(bank_in)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q_o) && $stable(bank_q_o));
endmodule

// File: rtl/bank_pick.sv
module bank_pick
    import bank_dec_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  mode_e             mode,
    input  logic [BANK_W-1:0] field,
    input  logic              sel,
    output logic [BANK_W-1:0] bank
);
    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);
    localparam logic [BANK_W-1:0] BANK_TWO = BANK_W'(2);

    always_comb begin
        unique case (mode)
            MD_FLASH, MD_SROM, MD_SRAM: bank = field;
            MD_ROMRAM, MD_RAM1:         bank = BANK_ONE;
            MD_RAM2:                    bank = sel ? BANK_TWO : BANK_ONE;
            default:                    bank = '0;
        endcase
    end
endmodule

// File: rtl/src_pick.sv
module src_pick
    import bank_dec_pkg::*;
#(
    parameter int BOOT_BLK = 5
) (
    input  mode_e            mode,
    input  logic [BLK_W-1:0] blk,
    input  logic             sel,
    output src_e             src
);
    localparam logic [BLK_W-1:0] BOOT_IDX = BLK_W'(BOOT_BLK);

    always_comb begin
        unique case (mode)
            MD_BOOT:                    src = (blk == BOOT_IDX) ? SRC_FLASH : SRC_LAST;
            MD_FLASH, MD_SROM:          src = SRC_FLASH;
            MD_ROMRAM:                  src = sel ? SRC_FLASH : SRC_RAM;
            MD_RAM1, MD_RAM2, MD_SRAM:  src = SRC_RAM;
            default:                    src = SRC_LAST;
        endcase
    end
endmodule

// File: rtl/bank_src_decoder.sv
module bank_src_decoder
    import bank_dec_pkg::*;
#(
    parameter int BANK_W   = 6,
    parameter int BOOT_BLK = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic [2:0]              cfg_mode,
    input  logic [BANK_W-1:0]       cfg_bank,
    input  logic [BLK_W-1:0]        acc_blk,
    input  logic                    acc_sel,
    input  logic [OFS_W-1:0]        acc_ofs,
    output logic [BANK_W-1:0]       bank_num,
    output logic [1:0]              data_src,
    output logic [BANK_W+OFS_W-1:0] phys_addr
);
    localparam logic [BLK_W-1:0] BOOT_IDX = BLK_W'(BOOT_BLK);

    mode_e             mode_q;
    logic [BANK_W-1:0] field_q;
    src_e              src_w;

    cfg_reg #(.BANK_W(BANK_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .mode_in  (cfg_mode),
        .bank_in  (cfg_bank),
        .mode_q_o (mode_q),
        .bank_q_o (field_q)
    );

    bank_pick #(.BANK_W(BANK_W)) u_bank (
        .mode  (mode_q),
        .field (field_q),
        .sel   (acc_sel),
        .bank  (bank_num)
    );

    src_pick #(.BOOT_BLK(BOOT_BLK)) u_src (
        .mode (mode_q),
        .blk  (acc_blk),
        .sel  (acc_sel),
        .src  (src_w)
    );

    assign data_src  = src_w;
    assign phys_addr = {bank_num, acc_ofs};

    // R7
    boot_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_BOOT && acc_blk != BOOT_IDX) |-> (data_src == 2'd0 && bank_num == '0));

    // R5
    ram2_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RAM2) |-> (bank_num == (acc_sel ? BANK_W'(2) : BANK_W'(1))));

    // R10
    spare_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_SPARE) |-> (data_src == 2'd0 && bank_num == '0));

    // R9
    romram_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_ROMRAM) |-> (data_src == (acc_sel ? 2'd1 : 2'd2)));

    // R11
    addr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFS_W-1:0] == acc_ofs);
endmodule

// File: tb/sim_bank_src_decoder.sv
module sim_bank_src_decoder;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [2:0]    cfg_mode = '0;
    logic [BW-1:0] cfg_bank = '0;
    logic [2:0]    acc_blk = '0;
    logic          acc_sel = 1'b0;
    logic [12:0]   acc_ofs = '0;
    logic [BW-1:0] bank_num;
    logic [1:0]    data_src;
    logic [BW+12:0] phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bank_src_decoder #(.BANK_W(BW), .BOOT_BLK(5)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_bank(cfg_bank), .acc_blk(acc_blk), .acc_sel(acc_sel), .acc_ofs(acc_ofs),
        .bank_num(bank_num), .data_src(data_src), .phys_addr(phys_addr)
    );

    function automatic logic [BW-1:0] want_bank(input logic [2:0] m, input logic [BW-1:0] f, input logic s);
        if (m == 3'd1 || m == 3'd2 || m == 3'd3) return f;
        if (m == 3'd4 || m == 3'd5) return BW'(1);
        if (m == 3'd6) return s ? BW'(2) : BW'(1);
        return '0;
    endfunction

    function automatic logic [1:0] want_src(input logic [2:0] m, input logic [2:0] b, input logic s);
        if (m == 3'd0) return (b == 3'd5) ? 2'd1 : 2'd0;
        if (m == 3'd1 || m == 3'd2) return 2'd1;
        if (m == 3'd4) return s ? 2'd1 : 2'd2;
        if (m == 3'd3 || m == 3'd5 || m == 3'd6) return 2'd2;
        return 2'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [2:0] m, input logic [BW-1:0] f);
        @(negedge clk);
        cfg_load = 1'b1; cfg_mode = m; cfg_bank = f;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic access(input string req, input logic [2:0] m, input logic [BW-1:0] f,
                          input logic [2:0] b, input logic s, input logic [12:0] o);
        logic [BW-1:0] eb;
        @(negedge clk);
        acc_blk = b; acc_sel = s; acc_ofs = o;
        #1;
        eb = want_bank(m, f, s);
        check(req, 32'(bank_num), 32'(eb));
        check(req, 32'(data_src), 32'(want_src(m, b, s)));
        check("R11", 32'(phys_addr), 32'({eb, o}));
    endtask

    task automatic t_reset;
        access("R1", 3'd0, '0, 3'd2, 1'b1, 13'h0abc);
        access("R1", 3'd0, '0, 3'd0, 1'b0, 13'h1fff);
    endtask

    task automatic t_boot;
        access("R7", 3'd0, '0, 3'd5, 1'b0, 13'h0123);
        access("R7", 3'd0, '0, 3'd4, 1'b1, 13'h0123);
        access("R6", 3'd0, '0, 3'd5, 1'b1, 13'h1000);
    endtask

    task automatic t_field_modes;
        for (int m = 1; m <= 3; m++) begin
            load_cfg(3'(m), BW'(6'h2d + m));
            access("R3", 3'(m), BW'(6'h2d + m), 3'd1, 1'b0, 13'h1555);
            access("R8", 3'(m), BW'(6'h2d + m), 3'd6, 1'b1, 13'h0aaa);
        end
        load_cfg(3'd1, 6'h3f);
        access("R3", 3'd1, 6'h3f, 3'd5, 1'b0, 13'h1fff);
    endtask

    task automatic t_fixed_modes;
        load_cfg(3'd4, 6'h33);
        access("R9", 3'd4, 6'h33, 3'd5, 1'b1, 13'h0042);
        access("R9", 3'd4, 6'h33, 3'd5, 1'b0, 13'h0042);
        access("R4", 3'd4, 6'h33, 3'd3, 1'b0, 13'h0007);
        load_cfg(3'd5, 6'h11);
        access("R4", 3'd5, 6'h11, 3'd1, 1'b1, 13'h1234);
        access("R8", 3'd5, 6'h11, 3'd1, 1'b0, 13'h0234);
    endtask

    task automatic t_ram2;
        load_cfg(3'd6, 6'h20);
        access("R5", 3'd6, 6'h20, 3'd2, 1'b1, 13'h0f0f);
        access("R5", 3'd6, 6'h20, 3'd2, 1'b0, 13'h10f0);
    endtask

    task automatic t_spare;
        load_cfg(3'd7, 6'h15);
        access("R10", 3'd7, 6'h15, 3'd5, 1'b1, 13'h0001);
        access("R6", 3'd7, 6'h15, 3'd3, 1'b0, 13'h0002);
    endtask

    task automatic t_no_load;
        load_cfg(3'd2, 6'h09);
        @(negedge clk);
        cfg_mode = 3'd5; cfg_bank = 6'h3c;
        @(negedge clk);
        access("R2", 3'd2, 6'h09, 3'd1, 1'b0, 13'h0777);
        load_cfg(3'd0, 6'h00);
        access("R2", 3'd0, 6'h00, 3'd1, 1'b0, 13'h0777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_boot();
        t_field_modes();
        t_fixed_modes();
        t_ram2();
        t_spare();
        t_no_load();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule